// File: doc/BRIEF.md
# Signed long division sequencer

This block divides a signed 32-bit dividend by a signed 16-bit divisor. It returns a full-width 32-bit signed quotient, truncated toward zero, and a 16-bit signed remainder. It works on magnitudes. After the operands are captured, the divisor is tested for zero. Both operands are then converted to non-negative values, and two flags record whether the dividend was negative and whether the operand signs differ.

A single radix-2 restoring unsigned core performs two chained 16-step passes:

- **First pass:** the zero-extended upper half of the dividend magnitude is divided by the divisor magnitude. This gives the upper 16 quotient bits and a partial remainder.
- **Second pass:** the partial remainder is concatenated with the lower half of the dividend magnitude and divided again. This gives the lower 16 quotient bits and the final remainder.

Signs are reapplied to the registered results in the last step. Because the quotient is built in two halves, no input pair can overflow it. The single wrapping case is −2^31 ÷ −1, which returns −2^31 and raises no flag.

A request is made by holding `start_i` high in a cycle where `ready_o` is high. Results appear with a one-cycle `done_o` pulse and stay on the outputs until the next request completes.

The controller has five states:

| State | Role | Transitions |
|---|---|---|
| IDLE | Ready; captures operands on start | `accept` → CHECK |
| CHECK | Tests the divisor; loads the first pass | `zero_divisor` → DONE; `launch_high` → HIGH |
| HIGH | Runs the first pass | `chain_low` → LOW, when the core finishes and the second pass is loaded |
| LOW | Runs the second pass | `fix_signs` → DONE, registering the signed results |
| DONE | Pulses `done_o` | `release` → IDLE |

Top module: `sdiv_seq`

## Requirements
- R1: After reset `ready_o` is 1 and `done_o` is 0. `ready_o` is 1 only while idle, and a start is accepted only in a cycle where `ready_o` is 1.
- R2: For a nonzero divisor, `done_o` rises 35 clock edges after the accepting edge, and it is high for exactly one cycle.
- R3: For a divisor of zero, `done_o` and `div_zero_o` are 1 one edge after the accepting edge, and `quotient_o` and `remainder_o` are both 0.
- R4: For a nonzero divisor, `quotient_o` equals the dividend divided by the divisor, truncated toward zero, over the full 32-bit range, with `div_zero_o` 0.
- R5: `remainder_o` equals dividend − quotient × divisor. Its magnitude is below that of the divisor, and when it is nonzero its sign bit equals the dividend's sign bit.
- R6: The quotient is negative only when exactly one operand is negative.
- R7: A dividend of 0x80000000 divided by 0xFFFF (−1) gives a quotient of 0x80000000, a remainder of 0 and `div_zero_o` 0.
- R8: Operands are captured at the accepting edge. Later changes on the operand inputs, and a start pulse raised while busy, have no effect on the result.
- R9: `quotient_o`, `remainder_o` and `div_zero_o` change only at the edge that raises `done_o`, and they hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a division; taken only while ready_o is 1 |
| dividend_i | input | 32 | Signed dividend |
| divisor_i | input | 16 | Signed divisor |
| ready_o | output | 1 | Idle; able to accept a request |
| done_o | output | 1 | One-cycle completion pulse |
| quotient_o | output | 32 | Signed quotient |
| remainder_o | output | 16 | Signed remainder |
| div_zero_o | output | 1 | Divisor was zero |

## Verification
The bench crosses a grid of extreme dividends (0, ±1, ±2^31 ends, values on half-word boundaries) with extreme divisors (0, ±1, ±2, 0x7FFF, −32768). It then adds a long random sweep, and compares each result against 64-bit arithmetic computed in the bench.

Each of these corners exposes a specific fault:

- A design that chained the passes wrongly, or dropped the upper pass, would show wrong upper quotient bits on large dividends.
- A design that signed the remainder by the divisor would fail the mixed-sign cases.
- A design that treated the −32768 divisor magnitude as signed would produce garbage for that divisor.
- A design that flagged or saturated −2^31 ÷ −1 would be caught by the R7 check.

Every request also has its operand inputs scrambled after acceptance and a stray start raised mid-run. A design that sampled late or re-accepted would therefore return the wrong result or the wrong latency.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_HIGH,
        S_LOW,
        S_DONE
    } sdiv_state_e;
endpackage

// File: rtl/sdiv_cond_neg.sv
module sdiv_cond_neg #(
    parameter int W = 16
) (
    input  logic [W-1:0] val_i,
    input  logic         neg_i,
    output logic [W-1:0] val_o
);
    assign val_o = neg_i ? ({W{1'b0}} - val_i) : val_i;
endmodule

// File: rtl/sdiv_udiv_core.sv
module sdiv_udiv_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic         done_o,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q, num_q, den_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q, done_q;

    logic [W:0]    shifted, diff;
    logic          fits;
    logic [W-1:0]  rem_nxt;

    always_comb begin
        shifted = {rem_q, num_q[W-1]};
        fits    = shifted >= {1'b0, den_q};
        diff    = shifted - {1'b0, den_q};
        rem_nxt = fits ? diff[W-1:0] : shifted[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            num_q  <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else if (load_i) begin
            rem_q  <= rem_i;
            num_q  <= num_i;
            den_q  <= den_i;
            cnt_q  <= CW'(W);
            busy_q <= 1'b1;
            done_q <= 1'b0;
        end else if (busy_q) begin
            rem_q  <= rem_nxt;
            num_q  <= {num_q[W-2:0], fits};
            cnt_q  <= cnt_q - 1'b1;
            busy_q <= (cnt_q != CW'(1));
            done_q <= (cnt_q == CW'(1));
        end else begin
            done_q <= 1'b0;
        end
    end

    assign done_o = done_q;
    assign quo_o  = num_q;
    assign rem_o  = rem_q;

    // R4: restoring invariant, partial remainder stays below the divisor
    a_r4_rem_below_den: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (rem_q < den_q));

    // R2: each pass signals completion for a single cycle
    a_r2_core_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
endmodule

// File: rtl/sdiv_seq.sv
module sdiv_seq
    import sdiv_pkg::*;
#(
    parameter int DVS_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [2*DVS_W-1:0]   dividend_i,
    input  logic [DVS_W-1:0]     divisor_i,
    output logic                 ready_o,
    output logic                 done_o,
    output logic [2*DVS_W-1:0]   quotient_o,
    output logic [DVS_W-1:0]     remainder_o,
    output logic                 div_zero_o
);
    localparam int DVD_W = 2 * DVS_W;

    sdiv_state_e state_q, state_d;

    logic [DVD_W-1:0] dvd_q, mag_dvd, mag_dvd_q;
    logic [DVS_W-1:0] dvs_q, mag_dvs, mag_dvs_q;
    logic             qneg_q, dneg_q;
    logic [DVS_W-1:0] qhi_q;
    logic [DVD_W-1:0] quo_q, quo_signed;
    logic [DVS_W-1:0] rem_q, rem_signed;
    logic             dz_q;

    logic             core_load, core_done;
    logic [DVS_W-1:0] core_rem_in, core_num_in, core_den_in, core_quo, core_rem;
    logic             dvs_zero;

    assign dvs_zero = (dvs_q == '0);

    sdiv_cond_neg #(.W(DVD_W)) i_mag_dvd (
        .val_i(dvd_q), .neg_i(dvd_q[DVD_W-1]), .val_o(mag_dvd));
    sdiv_cond_neg #(.W(DVS_W)) i_mag_dvs (
        .val_i(dvs_q), .neg_i(dvs_q[DVS_W-1]), .val_o(mag_dvs));
    sdiv_cond_neg #(.W(DVD_W)) i_fix_quo (
        .val_i({qhi_q, core_quo}), .neg_i(qneg_q), .val_o(quo_signed));
    sdiv_cond_neg #(.W(DVS_W)) i_fix_rem (
        .val_i(core_rem), .neg_i(dneg_q), .val_o(rem_signed));

    always_comb begin
        core_load   = 1'b0;
        core_rem_in = core_rem;
        core_num_in = mag_dvd_q[DVS_W-1:0];
        core_den_in = mag_dvs_q;
        if (state_q == S_CHECK) begin
            core_load   = !dvs_zero;
            core_rem_in = '0;
            core_num_in = mag_dvd[DVD_W-1:DVS_W];
            core_den_in = mag_dvs;
        end else if (state_q == S_HIGH) begin
            core_load   = core_done;
        end
    end

    sdiv_udiv_core #(.W(DVS_W)) i_core (
        .clk(clk), .rst_n(rst_n), .load_i(core_load),
        .rem_i(core_rem_in), .num_i(core_num_in), .den_i(core_den_in),
        .done_o(core_done), .quo_o(core_quo), .rem_o(core_rem));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_i)   state_d = S_CHECK;
            S_CHECK: state_d = dvs_zero ? S_DONE : S_HIGH;
            S_HIGH:  if (core_done) state_d = S_LOW;
            S_LOW:   if (core_done) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dvd_q     <= '0;
            dvs_q     <= '0;
            mag_dvd_q <= '0;
            mag_dvs_q <= '0;
            qneg_q    <= 1'b0;
            dneg_q    <= 1'b0;
            qhi_q     <= '0;
            quo_q     <= '0;
            rem_q     <= '0;
            dz_q      <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start_i) begin
                    dvd_q <= dividend_i;
                    dvs_q <= divisor_i;
                end
                S_CHECK: begin
                    mag_dvd_q <= mag_dvd;
                    mag_dvs_q <= mag_dvs;
                    qneg_q    <= dvd_q[DVD_W-1] ^ dvs_q[DVS_W-1];
                    dneg_q    <= dvd_q[DVD_W-1];
                    if (dvs_zero) begin
                        quo_q <= '0;
                        rem_q <= '0;
                        dz_q  <= 1'b1;
                    end
                end
                S_HIGH: if (core_done) qhi_q <= core_quo;
                S_LOW: if (core_done) begin
                    quo_q <= quo_signed;
                    rem_q <= rem_signed;
                    dz_q  <= 1'b0;
                end
                S_DONE: ;
                default: ;
            endcase
        end
    end

    assign ready_o     = (state_q == S_IDLE);
    assign done_o      = (state_q == S_DONE);
    assign quotient_o  = quo_q;
    assign remainder_o = rem_q;
    assign div_zero_o  = dz_q;

    // R2: completion is a single-cycle pulse
    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3: zero divisor completes on the following edge
    a_r3_zero_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CHECK && dvs_zero) |=> (done_o && div_zero_o));

    // R3: zero-divide results are cleared
    a_r3_zero_result: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && div_zero_o) |-> (quotient_o == '0 && remainder_o == '0));

    // R5: nonzero remainder carries the dividend sign
    a_r5_rem_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !div_zero_o && remainder_o != '0)
            |-> (remainder_o[DVS_W-1] == dvd_q[DVD_W-1]));

    // R8: captured operands do not move while busy
    a_r8_capture_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |=> ($stable(dvd_q) && $stable(dvs_q)));

    // R9: results move only with the completion pulse
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(quotient_o) && $stable(remainder_o) && $stable(div_zero_o)));
endmodule

// File: tb/test_sdiv_seq.sv
module test_sdiv_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] dividend_i = '0;
    logic [15:0] divisor_i = '0;
    logic        ready_o, done_o, div_zero_o;
    logic [31:0] quotient_o;
    logic [15:0] remainder_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    sdiv_seq i_sdiv_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .dividend_i(dividend_i), .divisor_i(divisor_i),
        .ready_o(ready_o), .done_o(done_o), .quotient_o(quotient_o),
        .remainder_o(remainder_o), .div_zero_o(div_zero_o));

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] a, input logic [15:0] b);
        longint sa, sb, eq, er;
        int n;
        logic [31:0] q_seen;
        logic [15:0] r_seen;
        logic        z_seen;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        if (sb == 0) begin eq = 0; er = 0; end
        else begin eq = sa / sb; er = sa % sb; end
        @(negedge clk);
        check("R1 ready before start", ready_o, 1);
        start_i = 1'b1; dividend_i = a; divisor_i = b;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0; dividend_i = ~a; divisor_i = b ^ 16'h5A5A;
        n = 0;
        while (!done_o && n < 100) begin
            if (n == 0) check("R1 busy not ready", ready_o, 0);
            start_i = (n == 5);
            @(posedge clk);
            @(negedge clk);
            n++;
        end
        start_i = 1'b0;
        check(sb == 0 ? "R3 latency" : "R2 latency", n, sb == 0 ? 1 : 35);
        check("R3 zero flag", div_zero_o, sb == 0);
        check("R4 R6 R8 quotient", quotient_o, eq & 64'hFFFF_FFFF);
        check("R5 R8 remainder", remainder_o, er & 64'hFFFF);
        q_seen = quotient_o; r_seen = remainder_o; z_seen = div_zero_o;
        dividend_i = $urandom; divisor_i = 16'($urandom);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            check("R2 single pulse", done_o, 0);
            check("R9 hold", {q_seen, r_seen, z_seen} == {quotient_o, remainder_o, div_zero_o}, 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] dvds [12];
        logic [15:0] dvss [12];
        dvds = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7, 32'hFFFF_FFF9, 32'h7FFF_FFFF,
                 32'h8000_0000, 32'h0001_0000, 32'hFFFF_0000, 32'd123456789,
                 32'hF8A4_32EB, 32'h0000_FFFF};
        dvss = '{16'h0, 16'h1, 16'hFFFF, 16'h2, 16'hFFFE, 16'h3, 16'h7, 16'hFFF9,
                 16'h7FFF, 16'h8000, 16'h00FF, 16'hFFFD};
        repeat (2) @(negedge clk);
        check("R1 reset ready", ready_o, 1);
        check("R1 reset done", done_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", ready_o, 1);

        // R7: most negative dividend by minus one wraps
        run_op(32'h8000_0000, 16'hFFFF);
        check("R7 wrap quotient", quotient_o, 32'h8000_0000);
        check("R7 no flag", div_zero_o, 0);

        // R4 R5 R6 corner grid
        foreach (dvds[i]) foreach (dvss[j]) run_op(dvds[i], dvss[j]);

        // R4 R5 R6 random sweep
        for (int t = 0; t < 1500; t++) begin
            logic [15:0] d;
            d = (t % 4 == 0) ? 16'($signed(4'($urandom))) : 16'($urandom);
            run_op($urandom, d);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule